// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block decides, once per clock, what a small CPU core does with its exception traffic. It watches a 4-bit encoded external interrupt level, a strobe for general (synchronous) exceptions, and a strobe for the return-from-exception instruction. It also sees the core's current program counter and status word. The block owns the saved-PC and saved-status registers and the status word's block bit. It emits a registered redirect (target PC plus a valid pulse), the exception code of the accepted event, a status-load request for returns, and a reinitialisation pulse.

A controller state machine with two states, `ST_OPEN` (block bit clear) and `ST_BLOCKED` (block bit set), drives the behaviour. Every cycle a priority arbiter reduces the requests to one decision:

- `DEC_TAKE_GEN`: general exception accepted, OPEN to BLOCKED.
- `DEC_TAKE_IRQ`: interrupt accepted, OPEN to BLOCKED.
- `DEC_ESCALATE`: general exception while blocked, BLOCKED to BLOCKED with a reset-style reinitialisation.
- `DEC_RETURN`: either state, to the state named by the saved block bit.
- `DEC_UNBLOCK`: software clears the block bit, BLOCKED to OPEN.
- `DEC_BLOCK`: software sets the block bit, OPEN to BLOCKED.
- `DEC_IDLE`: no state change.

An interrupt raised while blocked is neither accepted nor lost. It stays visible on the level input and is taken as soon as the block bit clears.

Top module: `exc_entry_ctrl`

## Requirements
- R1: An accepted interrupt at level L sets `exc_code` to 0x200 + 32·L (level 2 gives 0x240, level 8 gives 0x300, level 14 gives 0x3C0).
- R2: Interrupt level 4'b1111 is not a request and is never accepted.
- R3: Events are accepted only while `bl` is 0. An interrupt level presented while `bl` is 1 produces no redirect and is taken at the first clock edge after `bl` has read 0.
- R4: Accepting a general exception or interrupt loads `saved_pc` with `cur_pc` and `saved_sr` with `cur_sr` with bit 28 (the block bit position) written as 0, and sets `bl` to 1, all at the same edge.
- R5: When a general exception and a valid interrupt level arrive in the same cycle while open, the general exception is taken and `exc_code` takes `gexc_code`.
- R6: A general exception while `bl` is 1 gives, one cycle later: `reinit_pulse` = 1, `redirect_valid` = 1, `redirect_pc` = 0xA0000000, `saved_pc` = `saved_sr` = 0, `exc_code` = 0 and `bl` = 1.
- R7: `rte_req` gives `redirect_valid` = 1, `redirect_pc` = the saved PC, `sr_load_valid` = 1 with `sr_load_val` = the saved status, and `bl` = bit 28 of the saved status.
- R8: While open, a return strobe takes precedence over an interrupt in the same cycle. The interrupt is taken on the following edge if still present.
- R9: After reset, `bl` = 1, `exc_code` = 0, both saved registers are 0 and no pulse output is high.
- R10: `exc_code` changes only when an event is accepted or escalated. Returns, block-bit writes and held interrupts leave it unchanged.
- R11: A block-bit write (`bl_wr_en`) with value 0 clears `bl` only when no event or return is taken. With value 1 it sets `bl` only in the same case. A write of the value `bl` already has changes nothing.
- R12: An accepted general exception redirects to 0x80000100 and an accepted interrupt to 0x80000600. `redirect_valid` is a single-cycle pulse, and `redirect_pc` and `sr_load_val` hold their values between pulses.
- R13: While blocked, a general exception takes precedence over a same-cycle return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_level | input | 4 | Encoded external interrupt level, 4'b1111 = none |
| gexc_req | input | 1 | General exception strobe |
| gexc_code | input | 12 | Code reported for the general exception |
| rte_req | input | 1 | Return-from-exception strobe |
| bl_wr_en | input | 1 | Software write of the block bit |
| bl_wr_val | input | 1 | Value for the block-bit write |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 32 | Current status word (bit 28 ignored) |
| bl | output | 1 | Block bit |
| exc_code | output | 12 | Code of the last accepted event |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| reinit_pulse | output | 1 | Reset-style reinitialisation request |
| sr_load_valid | output | 1 | Status restore pulse on return |
| sr_load_val | output | 32 | Status value to restore |
| saved_pc | output | 32 | Saved program counter |
| saved_sr | output | 32 | Saved status word |

## Verification
The hardest situation to reach is an interrupt held pending across a blocked period and then taken on exactly the first open cycle. The held level must outlive a return or software unblock that arrives in the same cycle as the interrupt. The stimulus holds a level steady while blocked, clears the block bit with that level still present, and then checks the redirect one edge later. A second directed pass places a return and an interrupt in the same open cycle. A long random phase mixes strobes at low rates, so that escalations from blocked exceptions and back-to-back returns come up repeatedly. A behavioural model compares every output on every clock.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [0:0] {
        ST_OPEN    = 1'b0,
        ST_BLOCKED = 1'b1
    } ctl_state_e;

    typedef enum logic [2:0] {
        DEC_IDLE,
        DEC_TAKE_GEN,
        DEC_TAKE_IRQ,
        DEC_ESCALATE,
        DEC_RETURN,
        DEC_UNBLOCK,
        DEC_BLOCK
    } decision_e;

endpackage

// File: rtl/exc_irq_decode.sv
module exc_irq_decode #(
    parameter int                LVL_W      = 4,
    parameter int                CODE_W     = 12,
    parameter logic [CODE_W-1:0] CODE_BASE  = 12'h200,
    parameter int                STEP_SHIFT = 5
) (
    input  logic [LVL_W-1:0]  level,
    output logic              req_valid,
    output logic [CODE_W-1:0] req_code
);
    localparam logic [LVL_W-1:0] LVL_NONE = {LVL_W{1'b1}};

    logic [CODE_W-1:0] lvl_ext;

    always_comb begin
        lvl_ext   = CODE_W'(level);
        req_valid = (level != LVL_NONE);
        req_code  = CODE_BASE + (lvl_ext << STEP_SHIFT);
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  ctl_state_e state,
    input  logic       gexc_req,
    input  logic       rte_req,
    input  logic       irq_valid,
    input  logic       bl_wr_en,
    input  logic       bl_wr_val,
    output decision_e  decision
);
    always_comb begin
        decision = DEC_IDLE;
        unique case (state)
            ST_OPEN: begin
                if (gexc_req)
                    decision = DEC_TAKE_GEN;
                else if (rte_req)
                    decision = DEC_RETURN;
                else if (irq_valid)
                    decision = DEC_TAKE_IRQ;
                else if (bl_wr_en && bl_wr_val)
                    decision = DEC_BLOCK;
            end
            ST_BLOCKED: begin
                if (gexc_req)
                    decision = DEC_ESCALATE;
                else if (rte_req)
                    decision = DEC_RETURN;
                else if (bl_wr_en && !bl_wr_val)
                    decision = DEC_UNBLOCK;
            end
            default: decision = DEC_IDLE;
        endcase
    end
endmodule

// File: rtl/exc_context.sv
module exc_context #(
    parameter int PC_W = 32,
    parameter int SR_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            clear,
    input  logic [PC_W-1:0] pc_in,
    input  logic [SR_W-1:0] sr_in,
    output logic [PC_W-1:0] saved_pc,
    output logic [SR_W-1:0] saved_sr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saved_pc <= '0;
            saved_sr <= '0;
        end else if (clear) begin
            saved_pc <= '0;
            saved_sr <= '0;
        end else if (capture) begin
            saved_pc <= pc_in;
            saved_sr <= sr_in;
        end
    end

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (saved_pc == '0 && saved_sr == '0));

    assert_capture_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !clear) |=> (saved_pc == $past(pc_in) && saved_sr == $past(sr_in)));

    assert_no_stray_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture && !clear) |=> ($stable(saved_pc) && $stable(saved_sr)));
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int                PC_W           = 32,
    parameter int                SR_W           = 32,
    parameter int                LVL_W          = 4,
    parameter int                CODE_W         = 12,
    parameter int                BL_BIT         = 28,
    parameter logic [CODE_W-1:0] IRQ_CODE_BASE  = 12'h200,
    parameter int                IRQ_CODE_SHIFT = 5,
    parameter logic [PC_W-1:0]   RESET_PC       = 32'hA000_0000,
    parameter logic [PC_W-1:0]   VEC_BASE       = 32'h8000_0000,
    parameter logic [PC_W-1:0]   GEN_OFS        = 32'h0000_0100,
    parameter logic [PC_W-1:0]   IRQ_OFS        = 32'h0000_0600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic              gexc_req,
    input  logic [CODE_W-1:0] gexc_code,
    input  logic              rte_req,
    input  logic              bl_wr_en,
    input  logic              bl_wr_val,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [SR_W-1:0]   cur_sr,
    output logic              bl,
    output logic [CODE_W-1:0] exc_code,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              reinit_pulse,
    output logic              sr_load_valid,
    output logic [SR_W-1:0]   sr_load_val,
    output logic [PC_W-1:0]   saved_pc,
    output logic [SR_W-1:0]   saved_sr
);
    localparam logic [PC_W-1:0] GEN_TARGET = VEC_BASE + GEN_OFS;
    localparam logic [PC_W-1:0] IRQ_TARGET = VEC_BASE + IRQ_OFS;

    ctl_state_e        state_q, state_d;
    decision_e         decision;
    logic              irq_valid;
    logic [CODE_W-1:0] irq_code;
    logic [SR_W-1:0]   cap_sr;
    logic              ctx_capture;
    logic              ctx_clear;

    exc_irq_decode #(
        .LVL_W     (LVL_W),
        .CODE_W    (CODE_W),
        .CODE_BASE (IRQ_CODE_BASE),
        .STEP_SHIFT(IRQ_CODE_SHIFT)
    ) u_irq_decode (
        .level    (irq_level),
        .req_valid(irq_valid),
        .req_code (irq_code)
    );

    exc_arbiter u_arbiter (
        .state    (state_q),
        .gexc_req (gexc_req),
        .rte_req  (rte_req),
        .irq_valid(irq_valid),
        .bl_wr_en (bl_wr_en),
        .bl_wr_val(bl_wr_val),
        .decision (decision)
    );

    always_comb begin
        cap_sr         = cur_sr;
        cap_sr[BL_BIT] = 1'b0;
        ctx_capture    = (decision == DEC_TAKE_GEN) || (decision == DEC_TAKE_IRQ);
        ctx_clear      = (decision == DEC_ESCALATE);
    end

    exc_context #(
        .PC_W(PC_W),
        .SR_W(SR_W)
    ) u_context (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (ctx_capture),
        .clear   (ctx_clear),
        .pc_in   (cur_pc),
        .sr_in   (cap_sr),
        .saved_pc(saved_pc),
        .saved_sr(saved_sr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (decision)
            DEC_TAKE_GEN, DEC_TAKE_IRQ, DEC_ESCALATE, DEC_BLOCK:
                state_d = ST_BLOCKED;
            DEC_UNBLOCK:
                state_d = ST_OPEN;
            DEC_RETURN:
                state_d = saved_sr[BL_BIT] ? ST_BLOCKED : ST_OPEN;
            DEC_IDLE:
                state_d = state_q;
            default:
                state_d = state_q;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BLOCKED;
        else        state_q <= state_d;
    end

    assign bl = (state_q == ST_BLOCKED);

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_code       <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            reinit_pulse   <= 1'b0;
            sr_load_valid  <= 1'b0;
            sr_load_val    <= '0;
        end else begin
            redirect_valid <= 1'b0;
            reinit_pulse   <= 1'b0;
            sr_load_valid  <= 1'b0;
            unique case (decision)
                DEC_TAKE_GEN: begin
                    exc_code       <= gexc_code;
                    redirect_valid <= 1'b1;
                    redirect_pc    <= GEN_TARGET;
                end
                DEC_TAKE_IRQ: begin
                    exc_code       <= irq_code;
                    redirect_valid <= 1'b1;
                    redirect_pc    <= IRQ_TARGET;
                end
                DEC_ESCALATE: begin
                    exc_code       <= '0;
                    redirect_valid <= 1'b1;
                    redirect_pc    <= RESET_PC;
                    reinit_pulse   <= 1'b1;
                end
                DEC_RETURN: begin
                    redirect_valid <= 1'b1;
                    redirect_pc    <= saved_pc;
                    sr_load_valid  <= 1'b1;
                    sr_load_val    <= saved_sr;
                end
                DEC_IDLE, DEC_UNBLOCK, DEC_BLOCK: begin
                end
                default: begin
                end
            endcase
        end
    end

    assert_blocked_holds_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bl && !gexc_req && !rte_req) |=> !redirect_valid);

    assert_irq_none_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gexc_req && !rte_req && irq_level == {LVL_W{1'b1}}) |=> !redirect_valid);

    assert_accept_sets_bl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bl && gexc_req) |=> (bl && saved_pc == $past(cur_pc)));

    assert_gexc_over_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bl && gexc_req) |=> (exc_code == $past(gexc_code) && redirect_pc == GEN_TARGET));

    assert_escalate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bl && gexc_req) |=> (reinit_pulse && bl && redirect_pc == RESET_PC && exc_code == '0));

    assert_return_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_req && !gexc_req) |=> (sr_load_valid && redirect_pc == $past(saved_pc)
                                    && sr_load_val == $past(saved_sr)));

    assert_code_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!gexc_req && (bl || !irq_valid || rte_req)) |=> $stable(exc_code));

    assert_redirect_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (!redirect_valid || $past(gexc_req || rte_req || irq_valid)));
endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RST_PC  = 32'hA000_0000;
    localparam logic [31:0] GEN_PC  = 32'h8000_0100;
    localparam logic [31:0] IRQ_PC  = 32'h8000_0600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_level = 4'hF;
    logic        gexc_req = 1'b0;
    logic [11:0] gexc_code = '0;
    logic        rte_req = 1'b0;
    logic        bl_wr_en = 1'b0;
    logic        bl_wr_val = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_sr = '0;
    logic        bl, redirect_valid, reinit_pulse, sr_load_valid;
    logic [11:0] exc_code;
    logic [31:0] redirect_pc, sr_load_val, saved_pc, saved_sr;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    logic        m_bl, m_rv, m_reinit, m_sv;
    logic [11:0] m_code;
    logic [31:0] m_rpc, m_sval, m_spc, m_ssr;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .gexc_req(gexc_req),
        .gexc_code(gexc_code), .rte_req(rte_req), .bl_wr_en(bl_wr_en),
        .bl_wr_val(bl_wr_val), .cur_pc(cur_pc), .cur_sr(cur_sr), .bl(bl),
        .exc_code(exc_code), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .reinit_pulse(reinit_pulse),
        .sr_load_valid(sr_load_valid), .sr_load_val(sr_load_val),
        .saved_pc(saved_pc), .saved_sr(saved_sr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_bl = 1'b1; m_rv = 1'b0; m_reinit = 1'b0; m_sv = 1'b0;
        m_code = '0; m_rpc = '0; m_sval = '0; m_spc = '0; m_ssr = '0;
    endtask

    task automatic model_return();
        m_rv = 1'b1; m_rpc = m_spc; m_sv = 1'b1; m_sval = m_ssr; m_bl = m_ssr[28];
    endtask

    task automatic model_step();
        m_rv = 1'b0; m_reinit = 1'b0; m_sv = 1'b0;
        if (m_bl) begin
            if (gexc_req) begin
                m_reinit = 1'b1; m_rv = 1'b1; m_rpc = RST_PC;
                m_spc = '0; m_ssr = '0; m_code = '0;
            end else if (rte_req) model_return();
            else if (bl_wr_en && !bl_wr_val) m_bl = 1'b0;
        end else begin
            if (gexc_req) begin
                m_spc = cur_pc; m_ssr = cur_sr & ~(32'd1 << 28); m_bl = 1'b1;
                m_code = gexc_code; m_rv = 1'b1; m_rpc = GEN_PC;
            end else if (rte_req) model_return();
            else if (irq_level != 4'hF) begin
                m_spc = cur_pc; m_ssr = cur_sr & ~(32'd1 << 28); m_bl = 1'b1;
                m_code = 12'h200 + 12'(irq_level) * 12'd32; m_rv = 1'b1; m_rpc = IRQ_PC;
            end else if (bl_wr_en && bl_wr_val) m_bl = 1'b1;
        end
    endtask

    task automatic compare_all();
        chk("R3", "bl", 32'(bl), 32'(m_bl));
        chk("R10", "exc_code", 32'(exc_code), 32'(m_code));
        chk("R12", "redirect_valid", 32'(redirect_valid), 32'(m_rv));
        chk("R12", "redirect_pc", redirect_pc, m_rpc);
        chk("R6", "reinit_pulse", 32'(reinit_pulse), 32'(m_reinit));
        chk("R7", "sr_load_valid", 32'(sr_load_valid), 32'(m_sv));
        chk("R7", "sr_load_val", sr_load_val, m_sval);
        chk("R4", "saved_pc", saved_pc, m_spc);
        chk("R4", "saved_sr", saved_sr, m_ssr);
    endtask

    // one clock: inputs already driven (at negedge), step model, compare after edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        compare_all();
        @(negedge clk);
    endtask

    task automatic drive(input logic [3:0] lvl, input logic g, input logic [11:0] gc,
                         input logic r, input logic we, input logic wv);
        irq_level = lvl; gexc_req = g; gexc_code = gc; rte_req = r;
        bl_wr_en = we; bl_wr_val = wv;
        cur_pc = cur_pc + 32'd4;
        cur_sr = {$urandom} | (32'd1 << 28);
    endtask

    task automatic idle();
        drive(4'hF, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        model_reset();
        cur_pc = 32'h0C00_0000;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "bl after reset", 32'(bl), 32'd1);
        chk("R9", "exc_code after reset", 32'(exc_code), 32'd0);
        chk("R9", "saved_pc after reset", saved_pc, 32'd0);
        chk("R9", "saved_sr after reset", saved_sr, 32'd0);
        chk("R9", "pulses after reset", 32'({redirect_valid, reinit_pulse, sr_load_valid}), 32'd0);
        rst_n = 1'b1;

        // R3: level 2 held while blocked, nothing taken
        drive(4'h2, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        repeat (3) begin cyc(); chk("R3", "no redirect while blocked", 32'(redirect_valid), 32'd0); end
        // R11: writing 1 while blocked changes nothing
        drive(4'h2, 1'b0, '0, 1'b0, 1'b1, 1'b1); cyc();
        chk("R11", "bl write 1 while blocked", 32'(bl), 32'd1);
        // unblock with level still present: irq not taken this edge
        drive(4'h2, 1'b0, '0, 1'b0, 1'b1, 1'b0); cyc();
        chk("R3", "unblock edge no redirect", 32'(redirect_valid), 32'd0);
        chk("R11", "bl cleared by write", 32'(bl), 32'd0);
        // first open cycle: pending taken
        drive(4'h2, 1'b0, '0, 1'b0, 1'b0, 1'b0); cyc();
        chk("R3", "pending irq taken first open cycle", 32'(redirect_valid), 32'd1);
        chk("R1", "code level 2", 32'(exc_code), 32'h240);
        chk("R12", "irq target", redirect_pc, IRQ_PC);
        chk("R4", "bl set on accept", 32'(bl), 32'd1);

        // R7: return, then R2 level F does nothing while open
        drive(4'hF, 1'b0, '0, 1'b1, 1'b0, 1'b0); cyc();
        chk("R7", "return bl from saved", 32'(bl), 32'd0);
        chk("R10", "code kept on return", 32'(exc_code), 32'h240);
        idle(); repeat (2) begin cyc(); chk("R2", "level F no redirect", 32'(redirect_valid), 32'd0); end

        // R5: gexc and level 8 together
        drive(4'h8, 1'b1, 12'h0E0, 1'b0, 1'b0, 1'b0); cyc();
        chk("R5", "gexc wins code", 32'(exc_code), 32'h0E0);
        chk("R12", "gexc target", redirect_pc, GEN_PC);
        drive(4'hF, 1'b0, '0, 1'b1, 1'b0, 1'b0); cyc();
        drive(4'h8, 1'b0, '0, 1'b0, 1'b0, 1'b0); cyc();
        chk("R1", "code level 8", 32'(exc_code), 32'h300);

        // R8: return over irq while open
        drive(4'hF, 1'b0, '0, 1'b1, 1'b0, 1'b0); cyc();
        drive(4'hE, 1'b0, '0, 1'b1, 1'b0, 1'b0); cyc();
        chk("R8", "return beats irq", 32'(sr_load_valid), 32'd1);
        chk("R8", "code unchanged", 32'(exc_code), 32'h300);
        drive(4'hE, 1'b0, '0, 1'b0, 1'b0, 1'b0); cyc();
        chk("R1", "code level 14", 32'(exc_code), 32'h3C0);

        // R13 + R6: blocked, gexc and rte together escalate
        drive(4'hF, 1'b1, 12'h1A0, 1'b1, 1'b0, 1'b0); cyc();
        chk("R13", "escalate beats return", 32'(sr_load_valid), 32'd0);
        chk("R6", "reinit pulse", 32'(reinit_pulse), 32'd1);
        chk("R6", "reset target", redirect_pc, RST_PC);
        chk("R6", "saved cleared", saved_pc, 32'd0);
        chk("R6", "code zeroed", 32'(exc_code), 32'd0);
        idle(); cyc();
        chk("R6", "pulse one cycle", 32'(reinit_pulse), 32'd0);

        // R11: software set in open
        drive(4'hF, 1'b0, '0, 1'b0, 1'b1, 1'b0); cyc();
        drive(4'hF, 1'b0, '0, 1'b0, 1'b1, 1'b0); cyc();
        chk("R11", "write 0 while open keeps open", 32'(bl), 32'd0);
        drive(4'hF, 1'b0, '0, 1'b0, 1'b1, 1'b1); cyc();
        chk("R11", "write 1 blocks", 32'(bl), 32'd1);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            drive(($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'hF,
                  $urandom_range(0, 11) == 0, 12'($urandom),
                  $urandom_range(0, 7) == 0, $urandom_range(0, 3) == 0, 1'($urandom));
            cyc();
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule